// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block is the issue stage of a core that interleaves many warps. Each warp owns a single slot that holds its next decoded instruction. A fetch channel places one instruction per cycle into the slot of whichever warp it names. A per-warp scoreboard records which destination registers still have results in flight, so every buffered instruction can be checked against it.

Each cycle the block may send one instruction down the execution pipe. It picks from the warps whose instruction has no operand or destination waiting on a write-back. The search goes round the warps and begins just after the warp that issued last. An issue occupies the pipe for `ISSUE_GAP` cycles, because a 32-thread warp needs four cycles to be dispatched. An external busy signal can also hold issue back. A small two-state machine controls when issue is allowed. In state `S_OPEN` issue is allowed. An issue moves it to `S_HOLD`. It returns to `S_OPEN` when the hold counter reaches `ISSUE_GAP-1`.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issue_valid` is 0, every slot is empty, no register is pending, and the round-robin search begins at warp 0.
- R2: `fetch_accept` is combinational. It is 1 exactly when `fetch_valid` is 1, `fetch_warp` is below `NUM_WARPS` (24), and that warp's slot is empty. A refused fetch changes no state, so it is never issued.
- R3: Instruction word layout: bits [15:12] are the destination, [11:8] source A, [7:4] source B and [3:0] the opcode. A buffered instruction is eligible only when none of source A, source B or the destination is pending for its warp.
- R4: Issuing marks the destination pending for that warp. A write-back (`wb_valid`, `wb_warp`, `wb_reg`) clears the bit. A write-back in the same cycle as the eligibility check already counts as ready. A write-back to another warp has no effect.
- R5: Among eligible warps, the one chosen is the first found searching upward from the warp after the last issuer, wrapping past warp 23.
- R6: At most one issue happens per cycle, and two issues are always at least `ISSUE_GAP` (4) cycles apart.
- R7: No issue is decided on a clock edge at which `pipe_busy` is 1.
- R8: `issue_valid` is a one-cycle registered pulse after the deciding edge, and it carries `issue_warp` and `issue_instr`. An instruction accepted at edge e can be decided at edge e+1 at the earliest.
- R9: A warp keeps issuing instructions that do not touch its pending registers while earlier results are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch channel carries an instruction |
| fetch_warp | input | 5 | Target warp of the fetch |
| fetch_instr | input | 16 | Fetched instruction word |
| fetch_accept | output | 1 | Fetch taken this cycle |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | 5 | Warp of the write-back |
| wb_reg | input | 4 | Register written back |
| pipe_busy | input | 1 | Execution pipe cannot take an issue |
| issue_valid | output | 1 | Issue pulse |
| issue_warp | output | 5 | Warp issued |
| issue_instr | output | 16 | Instruction issued |

## Verification
`fetch_accept` is due in the same cycle as the request, so the bench reads it a moment after driving, before the edge. An issue shows up one edge after the instruction is accepted, or one edge after the unblocking write-back or the release of `pipe_busy`. The bench drives each such event at a falling edge and samples at the next falling edge. When an issue must wait for the hold window or for a warp ahead of it, the bench collects every pulse at falling edges and compares the spacing in cycles and the order of warps. Stall checks confirm that `issue_valid` stays low for a fixed window of falling edges.

// File: rtl/wis_pkg.sv
package wis_pkg;
    localparam int REG_W    = 4;
    localparam int OP_W     = 4;
    localparam int NUM_REGS = 1 << REG_W;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [OP_W-1:0]  op;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef enum logic {S_OPEN, S_HOLD} iss_state_e;
endpackage

// File: rtl/wis_sboard.sv
module wis_sboard
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_WARPS-1:0]               slot_valid,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]    slot_dst,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]    slot_src_a,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]    slot_src_b,
    input  logic                               wb_valid,
    input  logic [WID_W-1:0]                   wb_warp,
    input  logic [REG_W-1:0]                   wb_reg,
    input  logic                               set_en,
    input  logic [WID_W-1:0]                   set_warp,
    input  logic [REG_W-1:0]                   set_reg,
    output logic [NUM_WARPS-1:0]               ready
);
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_REGS-1:0] pend_q;
        logic [NUM_REGS-1:0] clr_mask;
        logic [NUM_REGS-1:0] set_mask;
        logic [NUM_REGS-1:0] eff;

        always_comb begin
            clr_mask = '0;
            set_mask = '0;
            if (wb_valid && wb_warp == WID_W'(w))
                clr_mask = NUM_REGS'(1) << wb_reg;
            if (set_en && set_warp == WID_W'(w))
                set_mask = NUM_REGS'(1) << set_reg;
            // same-cycle write-back already counts as ready
            eff = pend_q & ~clr_mask;
            ready[w] = slot_valid[w] & ~eff[slot_src_a[w]]
                     & ~eff[slot_src_b[w]] & ~eff[slot_dst[w]];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= eff | set_mask;
        end
    end
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic [NUM_WARPS-1:0] req,
    input  logic [WID_W-1:0]     last,
    output logic                 grant_valid,
    output logic [WID_W-1:0]     grant_idx
);
    localparam logic [WID_W:0] N_EXT = (WID_W+1)'(NUM_WARPS);

    logic [WID_W:0] idx;

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        idx         = '0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            idx = {1'b0, last} + (WID_W+1)'(i);
            if (idx >= N_EXT) idx = idx - N_EXT;
            if (!grant_valid && req[idx[WID_W-1:0]]) begin
                grant_valid = 1'b1;
                grant_idx   = idx[WID_W-1:0];
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int ISSUE_GAP = 4,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [WID_W-1:0]   fetch_warp,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic               fetch_accept,
    input  logic               wb_valid,
    input  logic [WID_W-1:0]   wb_warp,
    input  logic [REG_W-1:0]   wb_reg,
    input  logic               pipe_busy,
    output logic               issue_valid,
    output logic [WID_W-1:0]   issue_warp,
    output logic [INSTR_W-1:0] issue_instr
);
    localparam int CNT_W = $clog2(ISSUE_GAP) + 1;

    iss_state_e                        state_q, state_d;
    logic [CNT_W-1:0]                  cnt_q;
    logic [NUM_WARPS-1:0]              slot_valid_q;
    instr_t [NUM_WARPS-1:0]            slot_instr_q;
    logic [NUM_WARPS-1:0][REG_W-1:0]   v_dst, v_sa, v_sb;
    logic [NUM_WARPS-1:0]              ready;
    logic [WID_W-1:0]                  last_q;
    logic                              grant_valid;
    logic [WID_W-1:0]                  grant_idx;
    logic                              do_issue;
    logic                              in_range;

    // fetch side
    assign in_range     = {1'b0, fetch_warp} < (WID_W+1)'(NUM_WARPS);
    assign fetch_accept = fetch_valid && in_range && !slot_valid_q[fetch_warp];

    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            v_dst[w] = slot_instr_q[w].dst;
            v_sa[w]  = slot_instr_q[w].src_a;
            v_sb[w]  = slot_instr_q[w].src_b;
        end
    end

    wis_sboard #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid_q),
        .slot_dst   (v_dst),
        .slot_src_a (v_sa),
        .slot_src_b (v_sb),
        .wb_valid   (wb_valid),
        .wb_warp    (wb_warp),
        .wb_reg     (wb_reg),
        .set_en     (do_issue),
        .set_warp   (grant_idx),
        .set_reg    (slot_instr_q[grant_idx].dst),
        .ready      (ready)
    );

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_rr (
        .req         (ready),
        .last        (last_q),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    assign do_issue = (state_q == S_OPEN) && !pipe_busy && grant_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: if (do_issue) state_d = S_HOLD;
            S_HOLD: if (cnt_q == CNT_W'(ISSUE_GAP - 1)) state_d = S_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (do_issue)              cnt_q <= CNT_W'(1);
            else if (state_q == S_HOLD) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // slots and round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid_q <= '0;
            slot_instr_q <= '0;
            last_q       <= WID_W'(NUM_WARPS - 1);
        end else begin
            for (int w = 0; w < NUM_WARPS; w++) begin
                if (do_issue && grant_idx == WID_W'(w))
                    slot_valid_q[w] <= 1'b0;
                if (fetch_accept && fetch_warp == WID_W'(w)) begin
                    slot_valid_q[w] <= 1'b1;
                    slot_instr_q[w] <= fetch_instr;
                end
            end
            if (do_issue) last_q <= grant_idx;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_instr <= '0;
        end else begin
            issue_valid <= do_issue;
            if (do_issue) begin
                issue_warp  <= grant_idx;
                issue_instr <= slot_instr_q[grant_idx];
            end
        end
    end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
    parameter int NUM_WARPS = 24,
    parameter int ISSUE_GAP = 4,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic [WID_W-1:0] fetch_warp,
    input logic             fetch_accept,
    input logic             pipe_busy,
    input logic             issue_valid,
    input logic [WID_W-1:0] issue_warp
);
    localparam int CW = $clog2(ISSUE_GAP) + 2;

    logic [CW-1:0] since_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (issue_valid) begin
            since_q <= CW'(1);
            seen_q  <= 1'b1;
        end else if (since_q < CW'(ISSUE_GAP)) begin
            since_q <= since_q + CW'(1);
        end
    end

    a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && seen_q) |-> since_q >= CW'(ISSUE_GAP));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_busy |=> !issue_valid);

    a_r2_accept_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_accept |-> (fetch_valid && ({1'b0, fetch_warp} < (WID_W+1)'(NUM_WARPS))));

    a_r5_warp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ({1'b0, issue_warp} < (WID_W+1)'(NUM_WARPS)));
endmodule

bind warp_issue_sched wis_checker #(.NUM_WARPS(NUM_WARPS), .ISSUE_GAP(ISSUE_GAP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_warp   (fetch_warp),
    .fetch_accept (fetch_accept),
    .pipe_busy    (pipe_busy),
    .issue_valid  (issue_valid),
    .issue_warp   (issue_warp)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 24;
    localparam int WW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_valid;
    logic [WW-1:0] fetch_warp;
    logic [15:0]   fetch_instr;
    logic          fetch_accept;
    logic          wb_valid;
    logic [WW-1:0] wb_warp;
    logic [3:0]    wb_reg;
    logic          pipe_busy;
    logic          issue_valid;
    logic [WW-1:0] issue_warp;
    logic [15:0]   issue_instr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    int got_w [8];
    int got_c [8];
    int got_n;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    warp_issue_sched #(.NUM_WARPS(NW), .ISSUE_GAP(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_instr(fetch_instr),
        .fetch_accept(fetch_accept),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .pipe_busy(pipe_busy),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_instr(issue_instr)
    );

    function automatic logic [15:0] mk(input int d, input int a, input int b, input int op);
        return {4'(d), 4'(a), 4'(b), 4'(op)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid = 0; fetch_warp = 0; fetch_instr = 0;
        wb_valid = 0; wb_warp = 0; wb_reg = 0; pipe_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input int w, input logic [15:0] ins, input logic exp_acc, input string tag);
        fetch_valid = 1'b1; fetch_warp = WW'(w); fetch_instr = ins;
        #1 chk(tag, 32'(fetch_accept), 32'(exp_acc));
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, 32'(issue_valid), 0);
        end
    endtask

    task automatic collect(input int maxc);
        got_n = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (issue_valid && got_n < 8) begin
                got_w[got_n] = int'(issue_warp);
                got_c[got_n] = cyc;
                got_n++;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 issue_valid after reset", 32'(issue_valid), 0);
        fetch_valid = 1'b1; fetch_warp = 0; fetch_instr = mk(1, 2, 3, 0);
        #1 chk("R1 empty slot accepts", 32'(fetch_accept), 1);
        fetch_valid = 1'b0;
        quiet(3, "R1 no issue with empty slots");
    endtask

    task automatic t_basic();
        do_reset();
        push(2, mk(5, 1, 2, 9), 1, "R2 accept warp2");
        chk("R8 not yet issued", 32'(issue_valid), 0);
        @(negedge clk);
        chk("R8 issue_valid", 32'(issue_valid), 1);
        chk("R8 issue_warp", 32'(issue_warp), 2);
        chk("R8 issue_instr", 32'(issue_instr), 32'(mk(5, 1, 2, 9)));
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(issue_valid), 0);
    endtask

    task automatic t_refuse();
        do_reset();
        pipe_busy = 1'b1;
        push(3, mk(1, 0, 0, 1), 1, "R2 first fetch warp3");
        push(3, mk(2, 0, 0, 2), 0, "R2 full slot refused");
        push(30, mk(3, 0, 0, 3), 0, "R2 out-of-range warp refused");
        quiet(2, "R7 busy holds issue");
        pipe_busy = 1'b0;
        @(negedge clk);
        chk("R7 issue after release", 32'(issue_valid), 1);
        chk("R2 kept first instr", 32'(issue_instr), 32'(mk(1, 0, 0, 1)));
        push(3, mk(2, 0, 0, 2), 1, "R2 slot free after issue");
        collect(12);
        chk("R2 exactly one more issue", 32'(got_n), 1);
        chk("R2 that issue is warp3", 32'(got_w[0]), 3);
    endtask

    task automatic t_sboard();
        do_reset();
        push(2, mk(5, 1, 2, 0), 1, "R4 setup");
        @(negedge clk);
        chk("R4 producer issued", 32'(issue_warp), 2);
        push(2, mk(6, 5, 0, 0), 1, "R3 consumer accept");
        push(4, mk(7, 1, 1, 0), 1, "R3 other warp accept");
        collect(10);
        chk("R3 one issue while blocked", 32'(got_n), 1);
        chk("R3 independent warp4 goes", 32'(got_w[0]), 4);
        wb_valid = 1'b1; wb_warp = 3; wb_reg = 5;
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R4 other-warp writeback ignored", 32'(issue_valid), 0);
        quiet(4, "R4 still blocked");
        wb_valid = 1'b1; wb_warp = 2; wb_reg = 5;
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R4 same-cycle writeback ready", 32'(issue_valid), 1);
        chk("R4 consumer warp", 32'(issue_warp), 2);
    endtask

    task automatic t_waw();
        do_reset();
        push(0, mk(3, 1, 2, 0), 1, "R3 setup");
        @(negedge clk);
        chk("R3 first issue", 32'(issue_valid), 1);
        push(0, mk(3, 4, 4, 0), 1, "R3 dst-hazard accept");
        quiet(8, "R3 pending destination blocks");
        wb_valid = 1'b1; wb_warp = 0; wb_reg = 3;
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R4 dst cleared issues", 32'(issue_valid), 1);
        push(0, mk(4, 1, 2, 7), 1, "R9 independent accept");
        collect(8);
        chk("R9 independent issues", 32'(got_n), 1);
        chk("R9 same warp", 32'(got_w[0]), 0);
    endtask

    task automatic t_gap();
        do_reset();
        pipe_busy = 1'b1;
        push(0, mk(1, 0, 0, 0), 1, "R6 fill0");
        push(1, mk(2, 0, 0, 0), 1, "R6 fill1");
        push(2, mk(3, 0, 0, 0), 1, "R6 fill2");
        pipe_busy = 1'b0;
        collect(16);
        chk("R6 issue count", 32'(got_n), 3);
        chk("R6 spacing 0-1", 32'(got_c[1] - got_c[0]), 4);
        chk("R6 spacing 1-2", 32'(got_c[2] - got_c[1]), 4);
        chk("R5 order first", 32'(got_w[0]), 0);
        chk("R5 order last", 32'(got_w[2]), 2);
    endtask

    task automatic t_rr();
        do_reset();
        pipe_busy = 1'b1;
        push(23, mk(1, 0, 0, 0), 1, "R5 fill23");
        push(1, mk(2, 0, 0, 0), 1, "R5 fill1");
        pipe_busy = 1'b0;
        collect(10);
        chk("R1 search starts at warp 0", 32'(got_w[0]), 1);
        chk("R5 then warp23", 32'(got_w[1]), 23);
        push(7, mk(3, 0, 0, 0), 1, "R5 fill7");
        collect(6);
        chk("R5 warp7 issued", 32'(got_w[0]), 7);
        pipe_busy = 1'b1;
        push(5, mk(4, 0, 0, 0), 1, "R5 fill5");
        push(9, mk(5, 0, 0, 0), 1, "R5 fill9");
        push(2, mk(6, 0, 0, 0), 1, "R5 fill2");
        pipe_busy = 1'b0;
        collect(14);
        chk("R5 count", 32'(got_n), 3);
        chk("R5 after 7 comes 9", 32'(got_w[0]), 9);
        chk("R5 wrap to 2", 32'(got_w[1]), 2);
        chk("R5 then 5", 32'(got_w[2]), 5);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_refuse();
        t_sboard();
        t_waw();
        t_gap();
        t_rr();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule